// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block drives one DMA channel from a chain of descriptors held in system memory. Software writes a 64-bit start pointer and turns on the channel in scatter-gather mode. The walker then reads each 64-byte descriptor one 32-bit word at a time over a plain memory read port. It keeps the fields the transfer engine needs and offers them as one segment over a valid/ready handshake.

After the engine signals that the segment is finished, the walker raises an interrupt pulse if the descriptor asked for one. It stops if the descriptor is marked last. Otherwise it follows the descriptor's next pointer. A ring is a chain whose final next pointer leads back to its first descriptor with the last flag clear, so the walker loops over it until software clears the run bit. Moving data is left to the engine.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset, `mem_req`, `seg_valid` and `irq` are low, and the control register (select 0) and the current-ID register (select 3) both read as zero.
- R2: The start pointer is written as a low word (select 1) and a high word (select 2). Bits 5:0 of the low word always read back as zero, so writing all-ones reads back 0xFFFFFFC0 (nonzero, which shows descriptor walking is present). The high word reads back as written. Register reads return data one clock after the select is applied.
- R3: A walk begins only when the control register is written with bit 0 (run) and bit 1 (scatter-gather mode) both set while the walker is idle. A control write with either bit clear issues no memory request.
- R4: A descriptor at pointer P is read as 16 words at byte addresses P, P+4, ... P+60, in ascending order, where P has bits 5:0 forced to zero. There is one request outstanding at a time, and each `mem_req` lasts a single cycle.
- R5: Little-endian word positions are: 0 flags, 1 ID, 2/3 destination address low/high, 4/5 source address low/high, 6/7 next pointer low/high, 8 row count, 9 row length, 10 source stride, 11 destination stride. Words 12–15 are ignored. The segment outputs carry these fields, and `seg_valid` stays high with stable fields until `seg_ready`.
- R6: No memory request is issued while a segment is offered or in progress. The next descriptor is fetched only after `seg_done` for the segment handed over. `seg_done` while no segment is in progress has no effect.
- R7: In the cycle after `seg_done`, `irq` pulses high for exactly one cycle if flags bit 1 is set, and stays low otherwise.
- R8: When flags bit 0 (last) is set, the walker goes idle after that segment completes and issues no further requests, whatever its next pointer holds.
- R9: A chain whose final next pointer returns to its first descriptor, with no last flag set, repeats indefinitely.
- R10: The current-ID register (select 3) holds the ID of the segment most recently accepted by the engine. Writes to it are ignored.
- R11: If run is cleared while a segment is in progress, the walker goes idle when that segment completes and fetches nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 pointer low, 2 pointer high, 3 current ID |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_sel` |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 64 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| seg_valid | output | 1 | Segment offered to the engine |
| seg_ready | input | 1 | Engine accepts the segment |
| seg_id | output | 32 | Segment ID |
| seg_dst_addr | output | 64 | Destination address |
| seg_src_addr | output | 64 | Source address |
| seg_rows | output | 32 | Row count field |
| seg_row_len | output | 32 | Row length field |
| seg_src_stride | output | 32 | Source stride |
| seg_dst_stride | output | 32 | Destination stride |
| seg_done | input | 1 | Engine finished the accepted segment |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The walker is tried on four patterns:
- A four-descriptor linear chain with mixed interrupt flags. This separates correct field positions and interrupt gating from swapped or shifted words.
- A next pointer carrying garbage in its low bits. This shows whether the alignment mask is applied.
- A last descriptor whose next pointer loops back. This tells a real stop apart from a walker that ignores the last flag.
- A two-entry ring walked for several laps, then stopped by clearing run mid-segment. This distinguishes endless repetition from a walker that halts early or ignores the stop request.

Memory latency varies per word, and the engine holds off `seg_ready` and `seg_done`, so the handshake and ordering rules are exercised under back-pressure.

// File: rtl/sg_walker_pkg.sv
package sg_walker_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_OFFER,
    ST_ACTIVE
  } walk_state_e;

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_PTR_LO = 2'd1;
  localparam logic [1:0] SEL_PTR_HI = 2'd2;
  localparam logic [1:0] SEL_CUR_ID = 2'd3;

  // word positions inside one descriptor
  localparam int unsigned WI_FLAGS  = 0;
  localparam int unsigned WI_ID     = 1;
  localparam int unsigned WI_DST    = 2;
  localparam int unsigned WI_SRC    = 4;
  localparam int unsigned WI_NEXT   = 6;
  localparam int unsigned WI_ROWS   = 8;
  localparam int unsigned WI_ROWLEN = 9;
  localparam int unsigned WI_SSTR   = 10;
  localparam int unsigned WI_DSTR   = 11;
  localparam int unsigned KEPT_WORDS = 12;

  localparam int unsigned FLAG_LAST_BIT = 0;
  localparam int unsigned FLAG_IRQ_BIT  = 1;
endpackage

// File: rtl/sg_walker_regs.sv
module sg_walker_regs
  import sg_walker_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned ALIGN_BITS = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en_i,
  input  logic [1:0]            sel_i,
  input  logic [WORD_W-1:0]     wdata_i,
  input  logic [WORD_W-1:0]     cur_id_i,
  input  logic                  idle_i,
  output logic [WORD_W-1:0]     rdata_o,
  output logic                  run_o,
  output logic                  sg_mode_o,
  output logic [2*WORD_W-1:0]   start_ptr_o,
  output logic                  go_o
);
  localparam int unsigned PTR_W = 2 * WORD_W;

  logic                     run_q, sgm_q;
  logic [WORD_W-1:ALIGN_BITS] ptr_lo_q;
  logic [WORD_W-1:0]        ptr_hi_q;
  logic [WORD_W-1:0]        rdata_q;
  logic                     ctrl_wr, lo_wr, hi_wr;

  assign ctrl_wr = wr_en_i && (sel_i == SEL_CTRL);
  assign lo_wr   = wr_en_i && (sel_i == SEL_PTR_LO);
  assign hi_wr   = wr_en_i && (sel_i == SEL_PTR_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      sgm_q    <= 1'b0;
      ptr_lo_q <= '0;
      ptr_hi_q <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q <= wdata_i[0];
        sgm_q <= wdata_i[1];
      end
      if (lo_wr) ptr_lo_q <= wdata_i[WORD_W-1:ALIGN_BITS];
      if (hi_wr) ptr_hi_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (sel_i)
        SEL_CTRL:   rdata_q <= {{(WORD_W-2){1'b0}}, sgm_q, run_q};
        SEL_PTR_LO: rdata_q <= {ptr_lo_q, {ALIGN_BITS{1'b0}}};
        SEL_PTR_HI: rdata_q <= ptr_hi_q;
        default:    rdata_q <= cur_id_i;
      endcase
    end
  end

  assign rdata_o     = rdata_q;
  assign run_o       = run_q;
  assign sg_mode_o   = sgm_q;
  assign start_ptr_o = PTR_W'({ptr_hi_q, ptr_lo_q, {ALIGN_BITS{1'b0}}});
  assign go_o        = ctrl_wr && wdata_i[0] && wdata_i[1] && idle_i;

  // R2: the low pointer word only moves on its own write
  p_ptr_lo_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !lo_wr |=> $stable(ptr_lo_q));
  // R3: launch only when both mode bits land while idle
  p_go_from_idle_r3: assert property (@(posedge clk) disable iff (rst)
    go_o |=> (run_q && sgm_q));
endmodule

// File: rtl/sg_desc_store.sv
module sg_desc_store #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned KEPT   = 12
) (
  input  logic                         clk,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic [KEPT-1:0][WORD_W-1:0]  words_o
);
  // one register per kept word; padding indices write nothing
  for (genvar g = 0; g < KEPT; g++) begin : g_word
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk) begin
      if (we_i && (idx_i == IDX_W'(g))) w_q <= wdata_i;
    end
    assign words_o[g] = w_q;
  end
endmodule

// File: rtl/sg_walker_fsm.sv
module sg_walker_fsm
  import sg_walker_pkg::*;
#(
  parameter int unsigned PTR_W      = 64,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned DESC_WORDS = 16,
  parameter int unsigned ALIGN_BITS = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           go_i,
  input  logic                           run_i,
  input  logic                           sg_mode_i,
  input  logic [PTR_W-1:0]               start_ptr_i,
  input  logic                           mem_rsp_valid_i,
  input  logic                           seg_ready_i,
  input  logic                           seg_done_i,
  input  logic                           flag_last_i,
  input  logic                           flag_irq_i,
  input  logic [PTR_W-1:0]               next_ptr_i,
  input  logic [WORD_W-1:0]              seg_id_i,
  output logic                           mem_req_o,
  output logic [PTR_W-1:0]               mem_addr_o,
  output logic                           store_we_o,
  output logic [$clog2(DESC_WORDS)-1:0]  store_idx_o,
  output logic                           seg_valid_o,
  output logic                           irq_o,
  output logic [WORD_W-1:0]              cur_id_o,
  output logic                           idle_o
);
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam logic [PTR_W-1:0] ALIGN_MASK = ~PTR_W'((64'd1 << ALIGN_BITS) - 64'd1);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(DESC_WORDS - 1);

  walk_state_e           state_q;
  logic [IDX_W-1:0]      idx_q;
  logic [PTR_W-1:0]      addr_q;
  logic                  req_q, valid_q, irq_q;
  logic [WORD_W-1:0]     cur_id_q;
  logic                  keep_going;

  assign keep_going = run_i && sg_mode_i && !flag_last_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      addr_q   <= '0;
      req_q    <= 1'b0;
      valid_q  <= 1'b0;
      irq_q    <= 1'b0;
      cur_id_q <= '0;
    end else begin
      req_q <= 1'b0;
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (go_i) begin
            addr_q  <= start_ptr_i & ALIGN_MASK;
            idx_q   <= '0;
            req_q   <= 1'b1;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid_i) begin
            if (idx_q == LAST_IDX) begin
              valid_q <= 1'b1;
              state_q <= ST_OFFER;
            end else begin
              idx_q  <= idx_q + 1'b1;
              addr_q <= addr_q + PTR_W'(WORD_BYTES);
              req_q  <= 1'b1;
            end
          end
        end
        ST_OFFER: begin
          if (seg_ready_i) begin
            valid_q  <= 1'b0;
            cur_id_q <= seg_id_i;
            state_q  <= ST_ACTIVE;
          end
        end
        default: begin
          if (seg_done_i) begin
            irq_q <= flag_irq_i;
            if (keep_going) begin
              addr_q  <= next_ptr_i & ALIGN_MASK;
              idx_q   <= '0;
              req_q   <= 1'b1;
              state_q <= ST_WAIT;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign mem_req_o   = req_q;
  assign mem_addr_o  = addr_q;
  assign store_we_o  = (state_q == ST_WAIT) && mem_rsp_valid_i;
  assign store_idx_o = idx_q;
  assign seg_valid_o = valid_q;
  assign irq_o       = irq_q;
  assign cur_id_o    = cur_id_q;
  assign idle_o      = (state_q == ST_IDLE);

  // R4: each word request is a single-cycle pulse
  p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);
  // R5: an offered segment stays offered until taken
  p_valid_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !seg_ready_i) |=> valid_q);
  // R6: no fetching while a segment is offered
  p_no_fetch_offer_r6: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> !req_q);
  // R7: interrupt is one cycle wide and follows a completion
  p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(seg_done_i));
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sg_walker_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned DESC_WORDS = 16,
  parameter int unsigned ALIGN_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_en,
  input  logic [1:0]           reg_sel,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic                 mem_req,
  output logic [2*WORD_W-1:0]  mem_addr,
  input  logic                 mem_rsp_valid,
  input  logic [WORD_W-1:0]    mem_rsp_data,
  output logic                 seg_valid,
  input  logic                 seg_ready,
  output logic [WORD_W-1:0]    seg_id,
  output logic [2*WORD_W-1:0]  seg_dst_addr,
  output logic [2*WORD_W-1:0]  seg_src_addr,
  output logic [WORD_W-1:0]    seg_rows,
  output logic [WORD_W-1:0]    seg_row_len,
  output logic [WORD_W-1:0]    seg_src_stride,
  output logic [WORD_W-1:0]    seg_dst_stride,
  input  logic                 seg_done,
  output logic                 irq
);
  localparam int unsigned PTR_W = 2 * WORD_W;
  localparam int unsigned IDX_W = $clog2(DESC_WORDS);

  logic                              go, run, sg_mode, idle;
  logic [PTR_W-1:0]                  start_ptr;
  logic [WORD_W-1:0]                 cur_id;
  logic                              store_we;
  logic [IDX_W-1:0]                  store_idx;
  logic [KEPT_WORDS-1:0][WORD_W-1:0] words;
  logic [PTR_W-1:0]                  next_ptr;
  logic                              unused_flag_bits;

  assign next_ptr         = {words[WI_NEXT+1], words[WI_NEXT]};
  assign unused_flag_bits = ^words[WI_FLAGS][WORD_W-1:2];

  sg_walker_regs #(
    .WORD_W(WORD_W), .ALIGN_BITS(ALIGN_BITS)
  ) i_regs (
    .clk(clk), .rst(rst),
    .wr_en_i(reg_wr_en), .sel_i(reg_sel), .wdata_i(reg_wdata),
    .cur_id_i(cur_id), .idle_i(idle),
    .rdata_o(reg_rdata), .run_o(run), .sg_mode_o(sg_mode),
    .start_ptr_o(start_ptr), .go_o(go)
  );

  sg_desc_store #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .KEPT(KEPT_WORDS)
  ) i_store (
    .clk(clk), .we_i(store_we), .idx_i(store_idx),
    .wdata_i(mem_rsp_data), .words_o(words)
  );

  sg_walker_fsm #(
    .PTR_W(PTR_W), .WORD_W(WORD_W),
    .DESC_WORDS(DESC_WORDS), .ALIGN_BITS(ALIGN_BITS)
  ) i_fsm (
    .clk(clk), .rst(rst),
    .go_i(go), .run_i(run), .sg_mode_i(sg_mode), .start_ptr_i(start_ptr),
    .mem_rsp_valid_i(mem_rsp_valid),
    .seg_ready_i(seg_ready), .seg_done_i(seg_done),
    .flag_last_i(words[WI_FLAGS][FLAG_LAST_BIT]),
    .flag_irq_i(words[WI_FLAGS][FLAG_IRQ_BIT]),
    .next_ptr_i(next_ptr), .seg_id_i(words[WI_ID]),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .store_we_o(store_we), .store_idx_o(store_idx),
    .seg_valid_o(seg_valid), .irq_o(irq),
    .cur_id_o(cur_id), .idle_o(idle)
  );

  assign seg_id         = words[WI_ID];
  assign seg_dst_addr   = {words[WI_DST+1], words[WI_DST]};
  assign seg_src_addr   = {words[WI_SRC+1], words[WI_SRC]};
  assign seg_rows       = words[WI_ROWS];
  assign seg_row_len    = words[WI_ROWLEN];
  assign seg_src_stride = words[WI_SSTR];
  assign seg_dst_stride = words[WI_DSTR];
endmodule

// File: tb/test_sg_chain_walker.sv
module test_sg_chain_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        seg_valid;
  logic        seg_ready = 1'b0;
  logic [31:0] seg_id;
  logic [63:0] seg_dst_addr, seg_src_addr;
  logic [31:0] seg_rows, seg_row_len, seg_src_stride, seg_dst_stride;
  logic        seg_done = 1'b0;
  logic        irq;

  always #4 clk = ~clk; // 125 MHz

  sg_chain_walker i_sg_chain_walker (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_id(seg_id),
    .seg_dst_addr(seg_dst_addr), .seg_src_addr(seg_src_addr),
    .seg_rows(seg_rows), .seg_row_len(seg_row_len),
    .seg_src_stride(seg_src_stride), .seg_dst_stride(seg_dst_stride),
    .seg_done(seg_done), .irq(irq)
  );

  // rows: flags, id, dst lo, dst hi, src lo, src hi, rows, row len, src stride, dst stride
  localparam int ROW_N = 4;
  localparam logic [31:0] VEC [0:39] = '{
    32'h2, 32'h11, 32'h8000_1000, 32'h1, 32'h4000_0000, 32'h0, 32'h3, 32'h3F, 32'h40, 32'h80,
    32'h0, 32'h22, 32'h9000_0000, 32'h2, 32'h0000_4100, 32'h0, 32'h0, 32'hFF, 32'h0,  32'h0,
    32'h2, 32'h33, 32'h1234_5678, 32'h0, 32'hCAFE_0000, 32'h7, 32'h9, 32'h10, 32'h20, 32'h30,
    32'h3, 32'h44, 32'hA5A5_0000, 32'h5, 32'h0BAD_0040, 32'h1, 32'h1, 32'h7,  32'h8,  32'hC
  };

  logic [31:0] mem [0:255];
  logic [63:0] req_log [0:63];
  int          req_cnt = 0;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] exp_row [0:9];
  logic [31:0] rd;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder: latency varies with address
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req) begin
        logic [63:0] a;
        int lat;
        a = mem_addr;
        if (req_cnt < 64) req_log[req_cnt] = a;
        req_cnt++;
        lat = 1 + int'(a[3:2]) % 3;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem[a[9:2]];
      end
    end
  end

  task automatic put_desc(input int base, input logic [31:0] f [0:9], input logic [63:0] nxt);
    int w;
    w = base >> 2;
    mem[w+0] = f[0]; mem[w+1] = f[1];
    mem[w+2] = f[2]; mem[w+3] = f[3];
    mem[w+4] = f[4]; mem[w+5] = f[5];
    mem[w+6] = nxt[31:0]; mem[w+7] = nxt[63:32];
    mem[w+8] = f[6]; mem[w+9] = f[7]; mem[w+10] = f[8]; mem[w+11] = f[9];
    for (int k = 12; k < 16; k++) mem[w+k] = 32'hDEAD_0000 + k;
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // wait for an offer, hold it off, take it and check fields and fetch addresses
  task automatic take_seg(input logic [63:0] base, input string tag);
    int t;
    bit addr_ok;
    logic [63:0] bad;
    t = 0;
    while (!seg_valid && t < 400) begin @(negedge clk); t++; end
    chk(seg_valid, {tag, " R5 offer seen"}, 64'(seg_valid), 64'd1);
    addr_ok = (req_cnt == 16);
    bad = 64'(req_cnt);
    for (int k = 0; k < 16 && k < req_cnt; k++)
      if (req_log[k] != base + 64'(4*k)) begin addr_ok = 0; bad = req_log[k]; end
    chk(addr_ok, {tag, " R4 word addresses"}, bad, base);
    repeat (3) @(negedge clk);
    chk(seg_valid && req_cnt == 16, {tag, " R6 held offer, no fetch"}, 64'(req_cnt), 64'd16);
    chk(seg_id == exp_row[1], {tag, " R5 id"}, 64'(seg_id), 64'(exp_row[1]));
    chk(seg_dst_addr == {exp_row[3], exp_row[2]}, {tag, " R5 dst"}, seg_dst_addr, {exp_row[3], exp_row[2]});
    chk(seg_src_addr == {exp_row[5], exp_row[4]}, {tag, " R5 src"}, seg_src_addr, {exp_row[5], exp_row[4]});
    chk({seg_rows, seg_row_len} == {exp_row[6], exp_row[7]}, {tag, " R5 rows/len"},
        {seg_rows, seg_row_len}, {exp_row[6], exp_row[7]});
    chk({seg_src_stride, seg_dst_stride} == {exp_row[8], exp_row[9]}, {tag, " R5 strides"},
        {seg_src_stride, seg_dst_stride}, {exp_row[8], exp_row[9]});
    seg_ready = 1'b1;
    @(negedge clk);
    seg_ready = 1'b0;
    chk(!seg_valid, {tag, " R5 offer drops after ready"}, 64'(seg_valid), 64'd0);
    req_cnt = 0;
  endtask

  task automatic finish_seg(input bit exp_irq, input string tag);
    repeat (6) @(negedge clk);
    chk(req_cnt == 0, {tag, " R6 no fetch before done"}, 64'(req_cnt), 64'd0);
    seg_done = 1'b1;
    @(negedge clk);
    seg_done = 1'b0;
    chk(irq == exp_irq, {tag, " R7 irq after done"}, 64'(irq), 64'(exp_irq));
    @(negedge clk);
    chk(!irq, {tag, " R7 irq one cycle"}, 64'(irq), 64'd0);
  endtask

  initial begin
    logic [31:0] ra [0:9];
    logic [31:0] rb [0:9];
    for (int k = 0; k < 256; k++) mem[k] = 32'hF0F0_0000 + k;

    // R1: reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req && !seg_valid && !irq, "R1 outputs low", {61'd0, mem_req, seg_valid, irq}, 64'd0);
    reg_read(2'd0, rd); chk(rd == 0, "R1 control reads zero", 64'(rd), 64'd0);
    reg_read(2'd3, rd); chk(rd == 0, "R1 current id zero", 64'(rd), 64'd0);

    // R2: pointer readback
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_read(2'd1, rd); chk(rd == 32'hFFFF_FFC0, "R2 low word masked", 64'(rd), 64'hFFFF_FFC0);
    reg_write(2'd2, 32'h1234_5678);
    reg_read(2'd2, rd); chk(rd == 32'h1234_5678, "R2 high word", 64'(rd), 64'h1234_5678);

    // linear chain at 0x100, row 1 next pointer carries low garbage
    for (int r = 0; r < ROW_N; r++) begin
      logic [63:0] nx;
      for (int j = 0; j < 10; j++) ra[j] = VEC[r*10+j];
      nx = (r == ROW_N-1) ? 64'h100 : 64'(32'h100 + 32'h40*(r+1));
      if (r == 1) nx = nx | 64'h2C;
      put_desc(32'h100 + 32'h40*r, ra, nx);
    end
    reg_write(2'd1, 32'h0000_0100);
    reg_write(2'd2, 32'h0);

    // R3: incomplete control writes do not launch
    req_cnt = 0;
    reg_write(2'd0, 32'h1);
    repeat (10) @(negedge clk);
    reg_write(2'd0, 32'h2);
    repeat (10) @(negedge clk);
    chk(req_cnt == 0, "R3 no launch without both bits", 64'(req_cnt), 64'd0);

    reg_write(2'd0, 32'h3);
    for (int r = 0; r < ROW_N; r++) begin
      for (int j = 0; j < 10; j++) exp_row[j] = VEC[r*10+j];
      take_seg(64'(32'h100 + 32'h40*r), "chain");
      reg_read(2'd3, rd);
      chk(rd == exp_row[1], "R10 current id", 64'(rd), 64'(exp_row[1]));
      finish_seg(exp_row[0][1], "chain");
    end

    // R8: last descriptor stops the walk despite a looping next pointer
    repeat (30) @(negedge clk);
    chk(req_cnt == 0 && !seg_valid, "R8 idle after last", 64'(req_cnt), 64'd0);

    // R6: stray completion while idle
    seg_done = 1'b1; @(negedge clk); seg_done = 1'b0;
    chk(!irq, "R6 stray done ignored", 64'(irq), 64'd0);
    // R10: write to current id ignored
    reg_write(2'd3, 32'hFFFF);
    reg_read(2'd3, rd); chk(rd == 32'h44, "R10 id write ignored", 64'(rd), 64'h44);

    // R9: two-entry ring at 0x200
    for (int j = 0; j < 10; j++) begin ra[j] = VEC[j]; rb[j] = VEC[10+j]; end
    ra[0] = 32'h2; ra[1] = 32'hA0;
    rb[0] = 32'h0; rb[1] = 32'hA1;
    put_desc(32'h200, ra, 64'h240);
    put_desc(32'h240, rb, 64'h200);
    reg_write(2'd1, 32'h0000_0200);
    req_cnt = 0;
    reg_write(2'd0, 32'h3);
    for (int n = 0; n < 5; n++) begin
      for (int j = 0; j < 10; j++) exp_row[j] = (n % 2 == 0) ? ra[j] : rb[j];
      take_seg((n % 2 == 0) ? 64'h200 : 64'h240, "R9 ring");
      if (n == 4) reg_write(2'd0, 32'h2); // R11: clear run mid-segment
      finish_seg(exp_row[0][1], "ring");
    end
    repeat (30) @(negedge clk);
    chk(req_cnt == 0 && !seg_valid, "R11 stop after run cleared", 64'(req_cnt), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule